// File: doc/BRIEF.md
# Floating-Point Subtract Special-Case Resolver

This block sits in front of a double-precision subtract datapath that computes x minus y. It works out the class of each 64-bit operand: zero, normal, denormal, infinity, quiet NaN or signalling NaN. When the pair of classes fixes the answer without any alignment or rounding, the block produces the final 64-bit result itself, together with an invalid-operation flag. All other pairs go to the arithmetic datapath. For those pairs the block reports which operands are denormal, so the datapath can normalize them before it aligns the operands.

The outputs are registered. A result appears one clock after its operands are applied, and the block accepts a new pair on every cycle. The 2-bit rounding mode has one use here: it sets the sign of the zero produced when two zeros of equal sign are subtracted.

Top module: `fpsub_special`

## Requirements
- R1: While `rst` is high at a clock edge, all outputs are zero from the next cycle on. Otherwise every output reflects the inputs sampled at the previous rising edge.
- R2: If x is a signalling NaN (exponent all ones, fraction bit 51 clear, fraction nonzero), `spec_valid` and `invalid` are set. The result is x with fraction bit 51 set, whatever y is.
- R3: If y is a signalling NaN and x is not, `spec_valid` and `invalid` are set. The result is y with fraction bit 51 set.
- R4: If neither operand is a signalling NaN and x is a quiet NaN (exponent all ones, bit 51 set), the result is x unchanged. Otherwise, if y is a quiet NaN, the result is y unchanged. In both cases `invalid` stays clear.
- R5: For infinity minus infinity with different signs, the result is x. With equal signs, `invalid` is set and the result is the default NaN 0x7FF8000000000000.
- R6: For a finite x (zero, normal or denormal) minus infinity, the result is an infinity whose sign is the inverse of the sign of y.
- R7: For infinity minus any finite y, the result is x unchanged.
- R8: For zero minus zero with different signs, the result is x. With equal signs, the result is a zero whose sign is 1 only when `rnd_mode` is 2'b11 (toward negative infinity).
- R9: For a nonzero finite x minus zero, the result is x. For zero minus a nonzero finite y, the result is y with bit 63 inverted.
- R10: For any pair of normal or denormal operands, `spec_valid`, `invalid` and `spec_result` are zero. `x_denorm` and `y_denorm` mark each operand whose exponent is zero and whose fraction is nonzero. Both flags are zero whenever `spec_valid` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_x | input | 64 | Minuend, IEEE 754 double |
| op_y | input | 64 | Subtrahend, IEEE 754 double |
| rnd_mode | input | 2 | Rounding mode; 2'b11 means toward negative infinity |
| spec_valid | output | 1 | Result was resolved here |
| spec_result | output | 64 | Resolved result (zero when not resolved) |
| invalid | output | 1 | Invalid-operation flag |
| x_denorm | output | 1 | x is denormal and goes to the datapath |
| y_denorm | output | 1 | y is denormal and goes to the datapath |

## Verification
The bench pits a signalling NaN in y against a quiet NaN in x. A resolver with the priority reversed would return x, not the quieted y, and would drop the invalid flag. It subtracts infinities of equal and of opposite sign. If the sign test is inverted, the design returns the default NaN where x was expected, or flags invalid on a legal operation. Zero minus zero is run under all four rounding modes, so a zero sign tied to the wrong mode shows up as a flipped bit 63. Denormal operands are tested alone, in pairs and mixed with normals. This catches flags that are raised on a resolved pair, or a denormal that is handled as a zero.

// File: rtl/fpsub_pkg.sv
package fpsub_pkg;
  typedef enum logic [2:0] {
    CL_ZERO  = 3'd0,
    CL_NORM  = 3'd1,
    CL_DNORM = 3'd2,
    CL_INF   = 3'd3,
    CL_QNAN  = 3'd4,
    CL_SNAN  = 3'd5
  } opclass_t;

  function automatic logic is_finite(opclass_t c);
    return (c == CL_ZERO) || (c == CL_NORM) || (c == CL_DNORM);
  endfunction
endpackage

// File: rtl/fpsub_classify.sv
module fpsub_classify
  import fpsub_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  localparam int W = 1 + EXP_W + FRAC_W
) (
  input  logic [W-1:0] operand,
  output opclass_t     cls
);
  localparam int QBIT = FRAC_W - 1;

  logic [EXP_W-1:0]  expo;
  logic [FRAC_W-1:0] frac;
  logic exp_max, exp_min, frac_nz;

  assign expo    = operand[W-2 -: EXP_W];
  assign frac    = operand[FRAC_W-1:0];
  assign exp_max = &expo;
  assign exp_min = ~|expo;
  assign frac_nz = |frac;

  always_comb begin
    if (exp_max) begin
      if (!frac_nz)         cls = CL_INF;
      else if (frac[QBIT])  cls = CL_QNAN;
      else                  cls = CL_SNAN;
    end else if (exp_min) begin
      cls = frac_nz ? CL_DNORM : CL_ZERO;
    end else begin
      cls = CL_NORM;
    end
  end
endmodule

// File: rtl/fpsub_pick.sv
module fpsub_pick
  import fpsub_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  parameter int RM_W   = 2,
  parameter logic [RM_W-1:0] RM_DOWN = 2'b11,
  localparam int W = 1 + EXP_W + FRAC_W
) (
  input  logic [W-1:0]    x,
  input  logic [W-1:0]    y,
  input  logic [RM_W-1:0] rm,
  input  opclass_t        cx,
  input  opclass_t        cy,
  output logic            hit,
  output logic [W-1:0]    res,
  output logic            inv,
  output logic            dx,
  output logic            dy
);
  localparam int QBIT = FRAC_W - 1;
  localparam logic [W-1:0] QMASK   = W'(1) << QBIT;
  localparam logic [W-1:0] EXPMASK = {1'b0, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
  localparam logic [W-1:0] DEF_NAN = EXPMASK | QMASK;
  localparam logic [W-1:0] SGNMASK = W'(1) << (W-1);

  logic sx, sy, fin_x, fin_y;
  assign sx    = x[W-1];
  assign sy    = y[W-1];
  assign fin_x = is_finite(cx);
  assign fin_y = is_finite(cy);

  always_comb begin
    hit = 1'b1;
    inv = 1'b0;
    res = '0;
    dx  = 1'b0;
    dy  = 1'b0;
    if (cx == CL_SNAN) begin
      res = x | QMASK;
      inv = 1'b1;
    end else if (cy == CL_SNAN) begin
      res = y | QMASK;
      inv = 1'b1;
    end else if (cx == CL_QNAN) begin
      res = x;
    end else if (cy == CL_QNAN) begin
      res = y;
    end else if (cx == CL_INF && cy == CL_INF) begin
      if (sx != sy) begin
        res = x;
      end else begin
        res = DEF_NAN;
        inv = 1'b1;
      end
    end else if (cy == CL_INF) begin
      res = EXPMASK | (sy ? '0 : SGNMASK);
    end else if (cx == CL_INF) begin
      res = x;
    end else if (cx == CL_ZERO && cy == CL_ZERO) begin
      if (sx != sy) res = x;
      else          res = (rm == RM_DOWN) ? SGNMASK : '0;
    end else if (cy == CL_ZERO && fin_x) begin
      res = x;
    end else if (cx == CL_ZERO && fin_y) begin
      res = y ^ SGNMASK;
    end else begin
      hit = 1'b0;
      dx  = (cx == CL_DNORM);
      dy  = (cy == CL_DNORM);
    end
  end
endmodule

// File: rtl/fpsub_special.sv
module fpsub_special
  import fpsub_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  parameter int RM_W   = 2,
  parameter logic [RM_W-1:0] RM_DOWN = 2'b11,
  localparam int W = 1 + EXP_W + FRAC_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [W-1:0]    op_x,
  input  logic [W-1:0]    op_y,
  input  logic [RM_W-1:0] rnd_mode,
  output logic            spec_valid,
  output logic [W-1:0]    spec_result,
  output logic            invalid,
  output logic            x_denorm,
  output logic            y_denorm
);
  localparam int N_OPS = 2;

  logic [W-1:0] ops [N_OPS];
  opclass_t     cls [N_OPS];

  assign ops[0] = op_x;
  assign ops[1] = op_y;

  for (genvar i = 0; i < N_OPS; i++) begin : g_cls
    fpsub_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
      .operand(ops[i]),
      .cls    (cls[i])
    );
  end

  logic         hit_c, inv_c, dx_c, dy_c;
  logic [W-1:0] res_c;

  fpsub_pick #(
    .EXP_W(EXP_W), .FRAC_W(FRAC_W), .RM_W(RM_W), .RM_DOWN(RM_DOWN)
  ) u_pick (
    .x  (op_x),
    .y  (op_y),
    .rm (rnd_mode),
    .cx (cls[0]),
    .cy (cls[1]),
    .hit(hit_c),
    .res(res_c),
    .inv(inv_c),
    .dx (dx_c),
    .dy (dy_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      spec_valid  <= 1'b0;
      spec_result <= '0;
      invalid     <= 1'b0;
      x_denorm    <= 1'b0;
      y_denorm    <= 1'b0;
    end else begin
      spec_valid  <= hit_c;
      spec_result <= res_c;
      invalid     <= inv_c;
      x_denorm    <= dx_c;
      y_denorm    <= dy_c;
    end
  end
endmodule

// File: rtl/fpsub_special_chk.sv
module fpsub_special_chk #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  parameter int RM_W   = 2,
  parameter logic [RM_W-1:0] RM_DOWN = 2'b11,
  localparam int W = 1 + EXP_W + FRAC_W
) (
  input logic            clk,
  input logic            rst,
  input logic [W-1:0]    op_x,
  input logic [W-1:0]    op_y,
  input logic [RM_W-1:0] rnd_mode,
  input logic            spec_valid,
  input logic [W-1:0]    spec_result,
  input logic            invalid,
  input logic            x_denorm,
  input logic            y_denorm
);
  localparam int QBIT = FRAC_W - 1;
  localparam logic [W-1:0] QMASK = W'(1) << QBIT;

  logic x_nan_e, y_nan_e, x_snan, y_snan, x_inf, y_inf, x_zero, y_zero;
  assign x_nan_e = &op_x[W-2 -: EXP_W];
  assign y_nan_e = &op_y[W-2 -: EXP_W];
  assign x_snan  = x_nan_e && !op_x[QBIT] && (|op_x[FRAC_W-1:0]);
  assign y_snan  = y_nan_e && !op_y[QBIT] && (|op_y[FRAC_W-1:0]);
  assign x_inf   = x_nan_e && ~|op_x[FRAC_W-1:0];
  assign y_inf   = y_nan_e && ~|op_y[FRAC_W-1:0];
  assign x_zero  = ~|op_x[W-2:0];
  assign y_zero  = ~|op_y[W-2:0];

  logic started;
  always_ff @(posedge clk) started <= 1'b1;

  p_reset_clear_r1: assert property (@(posedge clk) started && rst |=>
    !spec_valid && !invalid && !x_denorm && !y_denorm && spec_result == '0);

  p_snan_x_r2: assert property (@(posedge clk) disable iff (rst)
    x_snan |=> spec_valid && invalid && spec_result == ($past(op_x) | QMASK));

  p_snan_y_r3: assert property (@(posedge clk) disable iff (rst)
    (!x_snan && y_snan) |=> spec_valid && invalid && spec_result == ($past(op_y) | QMASK));

  p_inf_inf_r5: assert property (@(posedge clk) disable iff (rst)
    (x_inf && y_inf) |=> spec_valid && (invalid == ($past(op_x[W-1]) == $past(op_y[W-1]))));

  p_fin_minus_inf_r6: assert property (@(posedge clk) disable iff (rst)
    (!x_nan_e && y_inf) |=> spec_valid && !invalid &&
      spec_result[W-1] == !$past(op_y[W-1]) && spec_result[W-2:0] == $past(op_y[W-2:0]));

  p_zero_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (x_zero && y_zero && op_x[W-1] == op_y[W-1]) |=>
      spec_valid && spec_result == {($past(rnd_mode) == RM_DOWN), {(W-1){1'b0}}});

  p_denorm_passthru_r10: assert property (@(posedge clk) disable iff (rst)
    (x_denorm || y_denorm) |-> !spec_valid && !invalid);

  p_invalid_resolved_r2: assert property (@(posedge clk) disable iff (rst)
    invalid |-> spec_valid);
endmodule

bind fpsub_special fpsub_special_chk #(
  .EXP_W(EXP_W), .FRAC_W(FRAC_W), .RM_W(RM_W), .RM_DOWN(RM_DOWN)
) u_chk (
  .clk(clk), .rst(rst), .op_x(op_x), .op_y(op_y), .rnd_mode(rnd_mode),
  .spec_valid(spec_valid), .spec_result(spec_result), .invalid(invalid),
  .x_denorm(x_denorm), .y_denorm(y_denorm)
);

// File: tb/fpsub_special_bench.sv
module fpsub_special_bench;
  localparam int CLK_P = 10;
  localparam logic [63:0] DNAN = 64'h7FF8_0000_0000_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] op_x = '0, op_y = '0;
  logic [1:0]  rnd_mode = '0;
  logic        spec_valid, invalid, x_denorm, y_denorm;
  logic [63:0] spec_result;

  int checks = 0;
  int fails  = 0;

  always #(CLK_P/2) clk = ~clk;

  fpsub_special u_fpsub_special (
    .clk(clk), .rst(rst), .op_x(op_x), .op_y(op_y), .rnd_mode(rnd_mode),
    .spec_valid(spec_valid), .spec_result(spec_result), .invalid(invalid),
    .x_denorm(x_denorm), .y_denorm(y_denorm)
  );

  // kind: 0 zero, 1 normal, 2 denormal, 3 inf, 4 qnan, 5 snan
  function automatic int kind_of(logic [63:0] v);
    int e = int'(v[62:52]);
    if (e == 2047) begin
      if (v[51:0] == 0) return 3;
      return v[51] ? 4 : 5;
    end
    if (e == 0) return (v[51:0] == 0) ? 0 : 2;
    return 1;
  endfunction

  function automatic logic [63:0] make_op(int kind, bit sgn);
    logic [63:0] f = {$urandom(), $urandom()};
    logic [10:0] e;
    case (kind)
      0: return {sgn, 63'd0};
      1: begin
        e = 11'($urandom_range(2046, 1));
        return {sgn, e, f[51:0]};
      end
      2: return {sgn, 11'd0, f[51:1], 1'b1};
      3: return {sgn, 11'h7FF, 52'd0};
      4: return {sgn, 11'h7FF, 1'b1, f[50:0]};
      default: return {sgn, 11'h7FF, 1'b0, f[50:1], 1'b1};
    endcase
  endfunction

  typedef struct {
    logic        v;
    logic [63:0] r;
    logic        inv;
    logic        dx;
    logic        dy;
    string       tag;
  } exp_t;

  function automatic exp_t model(logic [63:0] x, logic [63:0] y, logic [1:0] rm);
    exp_t o;
    int kx = kind_of(x);
    int ky = kind_of(y);
    bit fx = (kx <= 2);
    bit fy = (ky <= 2);
    o.v = 1; o.r = 0; o.inv = 0; o.dx = 0; o.dy = 0;
    if (kx == 5)                    begin o.r = x; o.r[51] = 1; o.inv = 1; o.tag = "R2"; end
    else if (ky == 5)               begin o.r = y; o.r[51] = 1; o.inv = 1; o.tag = "R3"; end
    else if (kx == 4)               begin o.r = x; o.tag = "R4"; end
    else if (ky == 4)               begin o.r = y; o.tag = "R4"; end
    else if (kx == 3 && ky == 3) begin
      o.tag = "R5";
      if (x[63] != y[63]) o.r = x;
      else begin o.r = DNAN; o.inv = 1; end
    end
    else if (ky == 3)               begin o.r = {~y[63], 11'h7FF, 52'd0}; o.tag = "R6"; end
    else if (kx == 3)               begin o.r = x; o.tag = "R7"; end
    else if (kx == 0 && ky == 0) begin
      o.tag = "R8";
      o.r = (x[63] != y[63]) ? x : {(rm == 2'b11), 63'd0};
    end
    else if (ky == 0 && fx)         begin o.r = x; o.tag = "R9"; end
    else if (kx == 0 && fy)         begin o.r = {~y[63], y[62:0]}; o.tag = "R9"; end
    else begin
      o.v = 0; o.tag = "R10";
      o.dx = (kx == 2); o.dy = (ky == 2);
    end
    return o;
  endfunction

  task automatic compare(exp_t e);
    checks++;
    if (spec_valid !== e.v || spec_result !== e.r || invalid !== e.inv ||
        x_denorm !== e.dx || y_denorm !== e.dy) begin
      fails++;
      $display("FAIL %s: got v=%b r=%h inv=%b dx=%b dy=%b exp v=%b r=%h inv=%b dx=%b dy=%b",
               e.tag, spec_valid, spec_result, invalid, x_denorm, y_denorm,
               e.v, e.r, e.inv, e.dx, e.dy);
    end
  endtask

  exp_t pending;
  bit   have_pending = 0;

  // Drive one pair at a negedge; check the previous pair's result first.
  task automatic step(logic [63:0] x, logic [63:0] y, logic [1:0] rm);
    @(negedge clk);
    if (have_pending) compare(pending);
    op_x = x; op_y = y; rnd_mode = rm;
    pending = model(x, y, rm);
    have_pending = 1;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_P * 200000);
    fails++;
    $display("FAIL watchdog: got timeout exp completion");
    finish_run();
  end

  initial begin
    exp_t z;
    z.v = 0; z.r = 0; z.inv = 0; z.dx = 0; z.dy = 0; z.tag = "R1";
    op_x = 64'h7FF0_0000_0000_0001;
    op_y = 64'h0;
    repeat (3) @(negedge clk);
    compare(z);                                   // R1 reset clears outputs
    rst = 0;

    // R2 x sNaN vs y qNaN: x wins and is quieted
    step(64'h7FF0_0000_0000_0005, 64'hFFF8_0000_0000_0001, 2'b00);
    // R3 y sNaN beats x qNaN
    step(64'h7FF8_0000_0000_0002, 64'hFFF0_0000_0000_0009, 2'b00);
    // R4 qNaN in x beats qNaN in y; then y qNaN vs normal
    step(64'h7FF8_0000_0000_00AA, 64'h7FF8_0000_0000_00BB, 2'b00);
    step(64'h3FF0_0000_0000_0000, 64'hFFFC_0000_0000_0001, 2'b00);
    // R5 inf - inf
    step(64'h7FF0_0000_0000_0000, 64'hFFF0_0000_0000_0000, 2'b00);
    step(64'h7FF0_0000_0000_0000, 64'h7FF0_0000_0000_0000, 2'b00);
    step(64'hFFF0_0000_0000_0000, 64'hFFF0_0000_0000_0000, 2'b11);
    // R6 finite - inf
    step(64'h0000_0000_0000_0000, 64'h7FF0_0000_0000_0000, 2'b00);
    step(64'h0000_0000_0000_0001, 64'hFFF0_0000_0000_0000, 2'b00);
    // R7 inf - finite
    step(64'hFFF0_0000_0000_0000, 64'h4000_0000_0000_0000, 2'b00);
    step(64'h7FF0_0000_0000_0000, 64'h8000_0000_0000_0000, 2'b00);
    // R8 zero - zero under every rounding mode
    for (int m = 0; m < 4; m++) begin
      step(64'h0, 64'h0, 2'(m));
      step(64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 2'(m));
      step(64'h8000_0000_0000_0000, 64'h0, 2'(m));
    end
    // R9 finite - zero and zero - finite
    step(64'h0000_0000_0000_0003, 64'h8000_0000_0000_0000, 2'b00);
    step(64'h8000_0000_0000_0000, 64'hC008_0000_0000_0000, 2'b00);
    step(64'h0000_0000_0000_0000, 64'h000F_0000_0000_0000, 2'b11);
    // R10 datapath pairs with denormal flags
    step(64'h3FF0_0000_0000_0000, 64'h4000_0000_0000_0000, 2'b00);
    step(64'h0000_0000_0000_0001, 64'h3FF0_0000_0000_0000, 2'b00);
    step(64'h3FF0_0000_0000_0000, 64'h800F_FFFF_FFFF_FFFF, 2'b00);
    step(64'h0000_0000_0000_0001, 64'h8000_0000_0000_0002, 2'b00);

    // mixed random classes
    for (int n = 0; n < 4000; n++) begin
      step(make_op($urandom_range(5, 0), 1'($urandom())),
           make_op($urandom_range(5, 0), 1'($urandom())),
           2'($urandom()));
    end

    // R1 reset mid-run clears outputs
    @(negedge clk);
    compare(pending);
    have_pending = 0;
    rst = 1;
    op_x = 64'h7FF0_0000_0000_0000; op_y = 64'h7FF0_0000_0000_0000;
    @(negedge clk);
    compare(z);
    rst = 0;
    step(64'h0, 64'h0, 2'b11);
    @(negedge clk);
    compare(pending);
    finish_run();
  end
endmodule